// File: doc/BRIEF.md
# Reset Source Capture Controller

This block merges every reset request of the chip into one reset output. That reset is asserted without waiting for a clock edge. It is released cleanly on a clock edge, and only after a fixed hold time. The requests are power-on, brownout, watchdog underflow, software request, external pin, illegal opcode, illegal memory access and serial-line break detection. Power-on arrives on the active-low `rst_ni`. The other seven are warm requests, each on its own pin.

A sticky cause register records every source seen during resets. Warm resets do not change it, so software can tell a cold start from a hot restart, and see which faults occurred since it last looked. Software reads the register directly and clears single bits by writing ones.

When the reset is released, the block also fixes the address of the first instruction fetch. That address is either zero or a boot address made from a programmable vector.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Any warm request, or `rst_ni` low, drives `sys_rst_no` low at once, with no clock edge needed.
- R2: Once `rst_ni` is high and all warm requests are low, `sys_rst_no` stays low for the next HOLD+1 rising edges. It goes high on rising edge HOLD+2 (HOLD defaults to 16). This is a two-flop release synchronizer followed by a HOLD-cycle stretch.
- R3: Cause bit positions are fixed. Bit 0 is power-on, bit 1 brownout, bit 2 watchdog and bit 3 software. Bit 4 is external, bit 5 illegal opcode, bit 6 illegal address and bit 7 serial break. A warm request held across at least one rising edge sets its own bit and no other bit.
- R4: `rst_ni` low forces `cause_o` to 8'h03 (power-on and brownout set, all other bits cleared).
- R5: Cause bits accumulate across warm resets. A bit falls only when `clr_en_i` is high at a rising edge with the matching `clr_mask_i` bit set (write-one-to-clear). Bits with a zero mask bit are left unchanged.
- R6: The serial-break bit survives all warm resets. Only a software clear or a power-on reset removes it.
- R7: At release, `start_addr_o` becomes {`boot_vec_i`, 8'h00} if cause bit 7 is set, `boot_stat_i` is 1 or `force_boot_i` is 1. Otherwise it becomes 16'h0000.
- R8: `start_addr_o` changes only on the edge where `sys_rst_no` rises. Between resets it ignores changes on the boot vector, boot status and force inputs.
- R9: A software request produces exactly the same reset pulse and start-address decision as any other warm request. Only cause bit 3 differs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| bor_req_i | input | 1 | Brownout reset request |
| wdt_req_i | input | 1 | Watchdog underflow reset request |
| sw_req_i | input | 1 | Software reset request |
| ext_req_i | input | 1 | External pin reset request |
| bad_op_req_i | input | 1 | Illegal opcode reset request |
| bad_addr_req_i | input | 1 | Illegal memory access reset request |
| brk_req_i | input | 1 | Serial break reset request |
| clr_en_i | input | 1 | Cause clear strobe |
| clr_mask_i | input | 8 | Bits to clear (one clears) |
| cause_o | output | 8 | Sticky reset cause register |
| boot_vec_i | input | 8 | High byte of the boot address |
| boot_stat_i | input | 1 | Boot status bit |
| force_boot_i | input | 1 | Strap forcing the boot address |
| sys_rst_no | output | 1 | Chip reset, active low |
| start_addr_o | output | 16 | First fetch address after reset |

## Verification
The hardest case is a warm reset in which the boot address is chosen only because of a serial-break flag left over from an earlier reset. The current request is from a different source, and the boot status and force inputs are low. To reach it, the stimulus raises a break request and then a watchdog request with both boot inputs low. It checks that the boot address is still taken, then clears bit 7 and shows the next reset falls back to zero. The stimulus also sweeps all seven warm sources under all four combinations of boot status and force. It changes the boot inputs after each release to confirm the latched address holds.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int CAUSE_W  = 8;
  localparam int C_POR    = 0;
  localparam int C_BOR    = 1;
  localparam int C_WDT    = 2;
  localparam int C_SW     = 3;
  localparam int C_EXT    = 4;
  localparam int C_BADOP  = 5;
  localparam int C_BADADR = 6;
  localparam int C_BRK    = 7;
  localparam logic [CAUSE_W-1:0] COLD_CAUSE = CAUSE_W'((1 << C_POR) | (1 << C_BOR));
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/rcc_rst_stretch.sv
module rcc_rst_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk_i,
  input  logic arst_i,
  output logic rel_o,
  output logic load_o
);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i)                            cnt_q <= '0;
    else if (s2_q && !rel_o)               cnt_q <= cnt_q + 1'b1;
  end

  assign rel_o  = (cnt_q == CNT_W'(HOLD));
  // pulse on the edge that releases reset
  assign load_o = s2_q && (cnt_q == CNT_W'(HOLD - 1));
endmodule

// File: rtl/rcc_cause_reg.sv
module rcc_cause_reg
  import rcc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  cause_t req_i,
  input  logic   clr_en_i,
  input  cause_t clr_mask_i,
  output cause_t cause_o
);
  cause_t s1_q, s2_q, cause_q;

  for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i]    <= 1'b0;
        s2_q[i]    <= 1'b0;
        cause_q[i] <= COLD_CAUSE[i];
      end else begin
        s1_q[i]    <= req_i[i];
        s2_q[i]    <= s1_q[i];
        cause_q[i] <= (cause_q[i] & ~(clr_en_i & clr_mask_i[i])) | s2_q[i];
      end
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rcc_boot_sel.sv
module rcc_boot_sel #(
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              brk_i,
  input  logic              boot_stat_i,
  input  logic              force_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] start_o
);
  localparam int LOW_W = ADDR_W - VEC_W;

  logic use_boot;
  assign use_boot = brk_i | boot_stat_i | force_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     start_o <= '0;
    else if (load_i) start_o <= use_boot ? {vec_i, {LOW_W{1'b0}}} : '0;
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int HOLD   = 16,
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bor_req_i,
  input  logic              wdt_req_i,
  input  logic              sw_req_i,
  input  logic              ext_req_i,
  input  logic              bad_op_req_i,
  input  logic              bad_addr_req_i,
  input  logic              brk_req_i,
  input  logic              clr_en_i,
  input  logic [7:0]        clr_mask_i,
  output logic [7:0]        cause_o,
  input  logic [VEC_W-1:0]  boot_vec_i,
  input  logic              boot_stat_i,
  input  logic              force_boot_i,
  output logic              sys_rst_no,
  output logic [ADDR_W-1:0] start_addr_o
);
  cause_t warm_req;
  logic   req_any, arst, rel, load;

  always_comb begin
    warm_req           = '0;
    warm_req[C_BOR]    = bor_req_i;
    warm_req[C_WDT]    = wdt_req_i;
    warm_req[C_SW]     = sw_req_i;
    warm_req[C_EXT]    = ext_req_i;
    warm_req[C_BADOP]  = bad_op_req_i;
    warm_req[C_BADADR] = bad_addr_req_i;
    warm_req[C_BRK]    = brk_req_i;
  end

  assign req_any = |warm_req;
  assign arst    = req_any | ~rst_ni;

  rcc_rst_stretch #(.HOLD(HOLD)) u_stretch (
    .clk_i  (clk_i),
    .arst_i (arst),
    .rel_o  (rel),
    .load_o (load)
  );

  rcc_cause_reg u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (warm_req),
    .clr_en_i   (clr_en_i),
    .clr_mask_i (clr_mask_i),
    .cause_o    (cause_o)
  );

  rcc_boot_sel #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_boot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .brk_i       (cause_o[C_BRK]),
    .boot_stat_i (boot_stat_i),
    .force_i     (force_boot_i),
    .vec_i       (boot_vec_i),
    .start_o     (start_addr_o)
  );

  assign sys_rst_no = rel;
endmodule

// File: rtl/rst_cause_ctrl_chk.sv
module rst_cause_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_any_i,
  input logic              sys_rst_no_i,
  input logic [7:0]        cause_i,
  input logic              clr_en_i,
  input logic [7:0]        clr_mask_i,
  input logic [ADDR_W-1:0] start_i
);
  p_req_forces_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_any_i |-> !sys_rst_no_i);

  p_release_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no_i) |-> (!$past(req_any_i) && !$past(req_any_i, 2)));

  p_cause_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(cause_i) & ~($past(clr_en_i) ? $past(clr_mask_i) : 8'h00)) & ~cause_i) == 8'h00));

  p_brk_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cause_i[7]) && !($past(clr_en_i) && $past(clr_mask_i[7]))) |-> cause_i[7]);

  p_start_low_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i[ADDR_W-VEC_W-1:0] == '0);

  p_start_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no_i && $past(sys_rst_no_i)) |-> $stable(start_i));
endmodule

bind rst_cause_ctrl rst_cause_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_any_i    (req_any),
  .sys_rst_no_i (sys_rst_no),
  .cause_i      (cause_o),
  .clr_en_i     (clr_en_i),
  .clr_mask_i   (clr_mask_i),
  .start_i      (start_addr_o)
);

// File: tb/rst_cause_ctrl_tb.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  req;        // idx s -> cause bit s+1
  logic        clr_en;
  logic [7:0]  clr_mask;
  logic [7:0]  cause;
  logic [7:0]  vec;
  logic        stat, force_b;
  logic        sys_rst_n;
  logic [15:0] start;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_cause;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  rst_cause_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bor_req_i(req[0]), .wdt_req_i(req[1]), .sw_req_i(req[2]), .ext_req_i(req[3]),
    .bad_op_req_i(req[4]), .bad_addr_req_i(req[5]), .brk_req_i(req[6]),
    .clr_en_i(clr_en), .clr_mask_i(clr_mask), .cause_o(cause),
    .boot_vec_i(vec), .boot_stat_i(stat), .force_boot_i(force_b),
    .sys_rst_no(sys_rst_n), .start_addr_o(start)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_start();
    return (exp_cause[7] | stat | force_b) ? {vec, 8'h00} : 16'h0000;
  endfunction

  // called at the negedge where every request has just gone inactive
  task automatic check_release(input string tag);
    repeat (17) @(negedge clk);
    check(sys_rst_n == 1'b0, {tag, " R2 still held"}, 32'(sys_rst_n), 0);
    @(negedge clk);
    check(sys_rst_n == 1'b1, {tag, " R2 released"}, 32'(sys_rst_n), 1);
  endtask

  task automatic warm_reset(input int s, input int len);
    @(negedge clk);
    req[s] = 1'b1;
    #0.5;
    check(sys_rst_n == 1'b0, "R1 immediate assert", 32'(sys_rst_n), 0);
    repeat (len) @(negedge clk);
    req[s] = 1'b0;
    exp_cause |= 8'(1) << (s + 1);
    check_release(s == 2 ? "R9 sw" : "warm");
    check(cause == exp_cause, s == 2 ? "R9 R3 cause" : "R3 cause", 32'(cause), 32'(exp_cause));
    check(start == exp_start(), s == 2 ? "R9 R7 start" : "R7 start", 32'(start), 32'(exp_start()));
  endtask

  task automatic sw_clear(input logic [7:0] m);
    @(negedge clk);
    clr_en = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_en = 1'b0; clr_mask = 8'h00;
    exp_cause &= ~m;
    check(cause == exp_cause, "R5 w1c clear", 32'(cause), 32'(exp_cause));
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; req = '0; clr_en = 1'b0; clr_mask = 8'h00;
    vec = 8'h5A; stat = 1'b0; force_b = 1'b0;
    exp_cause = 8'h03;
    repeat (3) @(negedge clk);
    check(sys_rst_n == 1'b0, "R1 por held", 32'(sys_rst_n), 0);
    check(cause == 8'h03, "R4 por cause", 32'(cause), 32'h03);
    check(start == 16'h0, "R7 reset start", 32'(start), 0);
    rst_n = 1'b1;
    check_release("por");
    check(start == exp_start(), "R7 por start", 32'(start), 32'(exp_start()));

    // sweep: boot status x force x every warm source
    for (int c = 0; c < 4; c++) begin
      stat = c[0]; force_b = c[1];
      sw_clear(8'hFF);
      for (int s = 0; s < 7; s++) begin
        vec = 8'(8'h40 + c * 8 + s);
        warm_reset(s, 1 + (s % 3));
        held = start;
        @(negedge clk);
        vec = ~vec; stat = ~stat; force_b = ~force_b;
        repeat (3) @(negedge clk);
        check(start == held, "R8 start stable", 32'(start), 32'(held));
        vec = ~vec; stat = c[0]; force_b = c[1];
      end
    end

    // partial clear leaves other bits
    sw_clear(8'h0A);
    check(cause == 8'hF4, "R5 partial clear", 32'(cause), 32'hF4);

    // leftover break flag steers boot with status and force low
    stat = 1'b0; force_b = 1'b0; vec = 8'hC3;
    warm_reset(1, 2);
    check(cause[7] == 1'b1, "R6 brk kept", 32'(cause[7]), 1);
    check(start == 16'hC300, "R6 R7 boot from brk", 32'(start), 32'hC300);
    sw_clear(8'h80);
    warm_reset(3, 1);
    check(start == 16'h0000, "R7 zero after brk clear", 32'(start), 0);

    // cold reset in the middle of operation
    warm_reset(6, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check(sys_rst_n == 1'b0, "R1 por assert", 32'(sys_rst_n), 0);
    check(cause == 8'h03, "R4 R6 por clears brk", 32'(cause), 32'h03);
    exp_cause = 8'h03;
    repeat (2) @(negedge clk);
    stat = 1'b1; vec = 8'h7E;
    rst_n = 1'b1;
    check_release("por2");
    check(cause == 8'h03, "R4 cause after por", 32'(cause), 32'h03);
    check(start == 16'h7E00, "R7 por boot stat", 32'(start), 32'h7E00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule